// File: doc/BRIEF.md
# Caching agent request router

This block is the front end that every core request passes through on its way into a caching agent. In the cycle a request arrives, two things happen side by side. The address goes to a programmable range decoder that names the node responsible for that physical address. Cacheable reads also start a lookup in the local cache slice. Requests of other kinds, in particular the legacy I/O accesses, never touch the slice.

Both results are captured in registers. One cycle later the block issues exactly one outcome for the request. A slice hit is served locally. A miss, or a request that did no lookup, is forwarded to the decoded target. An address that falls in no range gets an error completion. The decode table holds a parameterised number of base/limit windows and is written through a simple configuration port. A slice-enable input turns every request into a miss when the slice is switched off.

Top module: `ca_req_router`

## Requirements
- R1: In the cycle a request arrives with opcode 3'd0 (cacheable read) or 3'd1 (read for ownership) and `slice_en` is 1, `lookup_valid` is 1 and `lookup_addr` equals `req_addr`.
- R2: Opcodes 3'd2 to 3'd7 (line write, uncached read, I/O read 3'd4, I/O write 3'd5, reserved) never raise `lookup_valid`. For these opcodes `lookup_hit` has no effect on the outcome.
- R3: Exactly one of `local_valid`, `fwd_valid` and `err_valid` is 1 in the cycle after each accepted request, and none is 1 after a cycle with no request. `out_addr` and `out_op` carry that request's address and opcode.
- R4: When a lookup was issued and `lookup_hit` was 1 in the request cycle, the outcome is `local_valid`. This holds whatever the decoder found.
- R5: A request with no hit whose address lies in one or more enabled ranges is forwarded. `fwd_target` is the target of the lowest-indexed matching range.
- R6: A range matches an address A when base <= A <= limit. Both bounds are inclusive.
- R7: A request with no hit whose address lies in no enabled range produces `err_valid` and is not forwarded.
- R8: While `slice_en` is 0, no lookup is issued and `lookup_hit` is ignored, so every request is decided as a miss.
- R9: A table write (`cfg_we`) affects requests from the next cycle on. A request in the same cycle as the write is decoded with the old contents. Writing with `cfg_en` = 0 disables that range.
- R10: After reset all outputs are 0 and every range is disabled, so any request completes with an error until ranges are programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | Physical address of the request |
| req_op | input | 3 | Request opcode |
| slice_en | input | 1 | Local cache slice is enabled |
| lookup_valid | output | 1 | Lookup issued to the slice this cycle |
| lookup_addr | output | ADDR_W | Address looked up in the slice |
| lookup_hit | input | 1 | Slice hit for the lookup issued this cycle |
| cfg_we | input | 1 | Write one range entry |
| cfg_idx | input | IDX_W | Range entry to write |
| cfg_en | input | 1 | Enable bit written to the entry |
| cfg_base | input | ADDR_W | Lowest address of the range |
| cfg_limit | input | ADDR_W | Highest address of the range |
| cfg_target | input | TGT_W | Target node of the range |
| local_valid | output | 1 | Request served by the local slice |
| fwd_valid | output | 1 | Request forwarded to `fwd_target` |
| fwd_target | output | TGT_W | Target node identifier (0 unless forwarding) |
| err_valid | output | 1 | Request hit no range: error completion |
| out_addr | output | ADDR_W | Address of the decided request |
| out_op | output | 3 | Opcode of the decided request |

## Verification
A corrupted range entry shows up at the ports one cycle after the first request that decodes through it. That request comes out with the wrong `fwd_target` or an error where a forward was due. A wrong captured lookup or hit flag turns a local service into a forward, or the other way round, in the cycle after the request. The bench plays overlapping ranges, exact bound addresses, I/O requests that carry a stray hit, the slice switched off, and table writes coinciding with requests. A random stream then follows, and the outcome is compared every cycle against a behavioural model.

// File: rtl/ca_router_pkg.sv
// Package: opcode and outcome encodings shared by the request router.
package ca_router_pkg;

    typedef enum logic [2:0] {
        OP_RD_DATA = 3'd0,
        OP_RD_OWN  = 3'd1,
        OP_WR_LINE = 3'd2,
        OP_RD_UNC  = 3'd3,
        OP_IO_RD   = 3'd4,
        OP_IO_WR   = 3'd5,
        OP_RSVD6   = 3'd6,
        OP_RSVD7   = 3'd7
    } req_op_e;

    // Only cacheable reads consult the local slice.
    function automatic logic op_needs_lookup(input logic [2:0] op);
        return (op == OP_RD_DATA) || (op == OP_RD_OWN);
    endfunction

endpackage

// File: rtl/ca_lookup_gate.sv
// Lookup gate: decides, in the request cycle, whether the local slice is
// consulted. Assumes the slice answers with a hit flag in the same cycle.
module ca_lookup_gate
    import ca_router_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_op,
    input  logic              slice_en,
    output logic              lookup_valid,
    output logic [ADDR_W-1:0] lookup_addr
);

    // Issue a lookup only for cacheable reads with the slice switched on.
    always_comb begin
        lookup_valid = req_valid && slice_en && op_needs_lookup(req_op);
        lookup_addr  = req_addr;
    end

endmodule

// File: rtl/ca_range_decoder.sv
// Range decoder: NRANGE base/limit windows, each with an enable and a
// target. All windows are compared in parallel; the lowest index wins.
// Assumes base <= limit is the programmer's duty; otherwise never matches.
module ca_range_decoder #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 4,
    parameter int NRANGE = 8,
    localparam int IDX_W = (NRANGE > 1) ? $clog2(NRANGE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic [TGT_W-1:0]  cfg_target,
    input  logic [ADDR_W-1:0] dec_addr,
    output logic              dec_match,
    output logic [TGT_W-1:0]  dec_target
);

    logic [NRANGE-1:0]             hit_vec;
    logic [NRANGE-1:0][TGT_W-1:0]  tgt_vec;

    for (genvar i = 0; i < NRANGE; i++) begin : g_range
        logic              en_q;
        logic [ADDR_W-1:0] base_q;
        logic [ADDR_W-1:0] limit_q;
        logic [TGT_W-1:0]  tgt_q;

        // Hold one table entry; written when the config index selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q    <= 1'b0;
                base_q  <= '0;
                limit_q <= '0;
                tgt_q   <= '0;
            end else if (cfg_we && (cfg_idx == IDX_W'(i))) begin
                en_q    <= cfg_en;
                base_q  <= cfg_base;
                limit_q <= cfg_limit;
                tgt_q   <= cfg_target;
            end
        end

        assign hit_vec[i] = en_q && (dec_addr >= base_q) && (dec_addr <= limit_q);
        assign tgt_vec[i] = tgt_q;
    end

    // Pick the lowest-indexed matching window.
    always_comb begin
        dec_match  = 1'b0;
        dec_target = '0;
        for (int i = NRANGE - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                dec_match  = 1'b1;
                dec_target = tgt_vec[i];
            end
        end
    end

endmodule

// File: rtl/ca_route_stage.sv
// Route stage: registers the lookup and decode results of the request
// cycle and, one cycle later, chooses local service, forward or error.
// Assumes at most one request per cycle.
module ca_route_stage #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_op,
    input  logic              lookup_valid,
    input  logic              lookup_hit,
    input  logic              dec_match,
    input  logic [TGT_W-1:0]  dec_target,
    output logic              local_valid,
    output logic              fwd_valid,
    output logic [TGT_W-1:0]  fwd_target,
    output logic              err_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [2:0]        out_op
);

    logic              vld_q;
    logic              hit_q;
    logic              match_q;
    logic [TGT_W-1:0]  tgt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        op_q;

    // Capture both parallel results; a hit counts only if a lookup was issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            hit_q   <= 1'b0;
            match_q <= 1'b0;
            tgt_q   <= '0;
            addr_q  <= '0;
            op_q    <= '0;
        end else begin
            vld_q   <= req_valid;
            hit_q   <= lookup_valid && lookup_hit;
            match_q <= dec_match;
            tgt_q   <= dec_target;
            addr_q  <= req_addr;
            op_q    <= req_op;
        end
    end

    // Decide the single outcome of the captured request.
    always_comb begin
        local_valid = vld_q && hit_q;
        fwd_valid   = vld_q && !hit_q && match_q;
        err_valid   = vld_q && !hit_q && !match_q;
        fwd_target  = fwd_valid ? tgt_q : '0;
        out_addr    = addr_q;
        out_op      = op_q;
    end

endmodule

// File: rtl/ca_req_router.sv
// Caching agent request router (top): lookup gate and range decoder work
// on the same request cycle; the route stage decides one cycle later.
// Assumes requests are always accepted (no back-pressure).
module ca_req_router #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 4,
    parameter int NRANGE = 8,
    localparam int IDX_W = (NRANGE > 1) ? $clog2(NRANGE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_op,
    input  logic              slice_en,
    output logic              lookup_valid,
    output logic [ADDR_W-1:0] lookup_addr,
    input  logic              lookup_hit,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic [TGT_W-1:0]  cfg_target,
    output logic              local_valid,
    output logic              fwd_valid,
    output logic [TGT_W-1:0]  fwd_target,
    output logic              err_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [2:0]        out_op
);

    logic             dec_match;
    logic [TGT_W-1:0] dec_target;

    ca_lookup_gate #(.ADDR_W(ADDR_W)) u_gate (
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_op       (req_op),
        .slice_en     (slice_en),
        .lookup_valid (lookup_valid),
        .lookup_addr  (lookup_addr)
    );

    ca_range_decoder #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .NRANGE(NRANGE)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_en     (cfg_en),
        .cfg_base   (cfg_base),
        .cfg_limit  (cfg_limit),
        .cfg_target (cfg_target),
        .dec_addr   (req_addr),
        .dec_match  (dec_match),
        .dec_target (dec_target)
    );

    ca_route_stage #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_op       (req_op),
        .lookup_valid (lookup_valid),
        .lookup_hit   (lookup_hit),
        .dec_match    (dec_match),
        .dec_target   (dec_target),
        .local_valid  (local_valid),
        .fwd_valid    (fwd_valid),
        .fwd_target   (fwd_target),
        .err_valid    (err_valid),
        .out_addr     (out_addr),
        .out_op       (out_op)
    );

endmodule

// File: rtl/ca_req_router_chk.sv
// Checker for the request router: port-level timing properties.
module ca_req_router_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_op,
    input logic              slice_en,
    input logic              lookup_valid,
    input logic [ADDR_W-1:0] lookup_addr,
    input logic              lookup_hit,
    input logic              local_valid,
    input logic              fwd_valid,
    input logic              err_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [2:0]        out_op
);

    // R1
    lookup_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |-> (req_valid && lookup_addr == req_addr));

    // R2
    io_no_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd4 || req_op == 3'd5)) |-> !lookup_valid);

    // R2
    no_lookup_no_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !lookup_valid) |=> !local_valid);

    // R3
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ($countones({local_valid, fwd_valid, err_valid}) == 1));

    // R3
    idle_no_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(local_valid || fwd_valid || err_valid));

    // R3
    carry_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_addr == $past(req_addr) && out_op == $past(req_op)));

    // R4
    hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && lookup_hit) |=> local_valid);

    // R8
    slice_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slice_en |-> !lookup_valid);

endmodule

bind ca_req_router ca_req_router_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_ca_req_router.sv
module tb_ca_req_router;

    localparam int AW = 32;
    localparam int TW = 4;
    localparam int NR = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_op = '0;
    logic          slice_en = 1'b1;
    logic          lookup_valid;
    logic [AW-1:0] lookup_addr;
    logic          lookup_hit = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic          cfg_en = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_limit = '0;
    logic [TW-1:0] cfg_target = '0;
    logic          local_valid, fwd_valid, err_valid;
    logic [TW-1:0] fwd_target;
    logic [AW-1:0] out_addr;
    logic [2:0]    out_op;

    ca_req_router #(.ADDR_W(AW), .TGT_W(TW), .NRANGE(NR)) dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string stim_tag = "";

    // Behavioural model state
    logic [AW-1:0] m_base [NR];
    logic [AW-1:0] m_lim  [NR];
    logic [TW-1:0] m_tgt  [NR];
    bit            m_en   [NR];
    int            e_kind = 0;          // 0 none, 1 local, 2 fwd, 3 err
    logic [AW-1:0] e_addr;
    logic [2:0]    e_op;
    logic [TW-1:0] e_tgt;
    string         e_tag = "R3";

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare against the model at every falling edge, then advance it.
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                for (int i = 0; i < NR; i++) m_en[i] = 1'b0;
                e_kind = 0;
                chk("R10", "outcomes in reset", {local_valid, fwd_valid, err_valid}, 3'b000);
            end else begin
                logic [2:0] ev;
                logic       exp_lk;
                ev = (e_kind == 1) ? 3'b100 : (e_kind == 2) ? 3'b010 :
                     (e_kind == 3) ? 3'b001 : 3'b000;
                chk(e_tag, "outcome {local,fwd,err}", {local_valid, fwd_valid, err_valid}, ev);
                if (e_kind != 0) begin
                    chk(e_tag, "out_addr", out_addr, e_addr);
                    chk(e_tag, "out_op", out_op, e_op);
                end
                chk(e_tag, "fwd_target", fwd_target, (e_kind == 2) ? e_tgt : '0);

                exp_lk = req_valid && slice_en && (req_op <= 3'd1);
                chk(!slice_en ? "R8" : (req_op <= 3'd1) ? "R1" : "R2",
                    "lookup_valid", lookup_valid, exp_lk);
                if (exp_lk) chk("R1", "lookup_addr", lookup_addr, req_addr);

                e_addr = req_addr;
                e_op   = req_op;
                e_tgt  = '0;
                if (!req_valid) e_kind = 0;
                else if (exp_lk && lookup_hit) e_kind = 1;
                else begin
                    e_kind = 3;
                    for (int i = NR - 1; i >= 0; i--)
                        if (m_en[i] && req_addr >= m_base[i] && req_addr <= m_lim[i]) begin
                            e_kind = 2;
                            e_tgt  = m_tgt[i];
                        end
                end
                if (stim_tag != "") e_tag = stim_tag;
                else e_tag = (e_kind == 1) ? "R4" : (e_kind == 2) ? "R5" :
                             (e_kind == 3) ? "R7" : "R3";

                if (cfg_we) begin
                    m_en[cfg_idx]   = cfg_en;
                    m_base[cfg_idx] = cfg_base;
                    m_lim[cfg_idx]  = cfg_limit;
                    m_tgt[cfg_idx]  = cfg_target;
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send(logic [AW-1:0] a, logic [2:0] op, logic hit, logic en);
        req_valid = 1'b1; req_addr = a; req_op = op; lookup_hit = hit; slice_en = en;
        step();
        req_valid = 1'b0; lookup_hit = 1'b0; slice_en = 1'b1;
    endtask

    task automatic set_range(int idx, logic en, logic [AW-1:0] b, logic [AW-1:0] l,
                             logic [TW-1:0] t);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_en = en;
        cfg_base = b; cfg_limit = l; cfg_target = t;
        step();
        cfg_we = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: nothing programmed yet, so the request errors
        stim_tag = "R10";
        send(32'h1000, 3'd3, 1'b0, 1'b1);
        stim_tag = "";
        set_range(0, 1'b1, 32'h1000, 32'h1FFF, 4'd1);
        set_range(1, 1'b1, 32'h1800, 32'h3FFF, 4'd2);
        set_range(3, 1'b1, 32'h8000, 32'h8000, 4'd5);
        set_range(7, 1'b1, 32'hF000, 32'hFFFF, 4'd7);
        // R1 / R4 hit served locally; R5 miss forwarded, overlap priority
        send(32'h1234, 3'd0, 1'b1, 1'b1);
        send(32'h1234, 3'd1, 1'b0, 1'b1);
        send(32'h1900, 3'd0, 1'b0, 1'b1);
        send(32'h2000, 3'd2, 1'b0, 1'b1);
        send(32'hF00D, 3'd3, 1'b0, 1'b1);
        // R6 inclusive bounds
        stim_tag = "R6";
        send(32'h0FFF, 3'd0, 1'b0, 1'b1);
        send(32'h1000, 3'd0, 1'b0, 1'b1);
        send(32'h3FFF, 3'd3, 1'b0, 1'b1);
        send(32'h4000, 3'd3, 1'b0, 1'b1);
        send(32'h7FFF, 3'd0, 1'b0, 1'b1);
        send(32'h8000, 3'd0, 1'b0, 1'b1);
        send(32'h8001, 3'd0, 1'b0, 1'b1);
        // R2 I/O ignores a stray hit
        stim_tag = "R2";
        send(32'h1234, 3'd4, 1'b1, 1'b1);
        send(32'h0500, 3'd5, 1'b1, 1'b1);
        send(32'h2000, 3'd6, 1'b1, 1'b1);
        // R8 slice off: hit ignored
        stim_tag = "R8";
        send(32'h1234, 3'd0, 1'b1, 1'b0);
        send(32'h0100, 3'd1, 1'b1, 1'b0);
        // R9 write in the same cycle as a request uses the old table
        stim_tag = "R9";
        cfg_we = 1'b1; cfg_idx = 3'd2; cfg_en = 1'b1;
        cfg_base = 32'h4000; cfg_limit = 32'h4FFF; cfg_target = 4'd9;
        send(32'h4100, 3'd0, 1'b0, 1'b1);
        cfg_we = 1'b0;
        send(32'h4100, 3'd0, 1'b0, 1'b1);
        set_range(0, 1'b0, 32'h1000, 32'h1FFF, 4'd1);
        send(32'h1234, 3'd0, 1'b0, 1'b1);
        send(32'h1900, 3'd0, 1'b0, 1'b1);
        stim_tag = "";
        // Random stream with occasional table rewrites
        for (int n = 0; n < 3000; n++) begin
            req_valid  = ($urandom_range(0, 3) != 0);
            req_addr   = $urandom_range(0, 32'h0000FFFF);
            req_op     = 3'($urandom_range(0, 7));
            lookup_hit = $urandom_range(0, 1);
            slice_en   = ($urandom_range(0, 7) != 0);
            cfg_we     = ($urandom_range(0, 15) == 0);
            if (cfg_we) begin
                logic [AW-1:0] b;
                b = $urandom_range(0, 32'h0000F000);
                cfg_idx = 3'($urandom_range(0, 7)); cfg_en = ($urandom_range(0, 3) != 0);
                cfg_base = b; cfg_limit = b + $urandom_range(0, 32'h2000);
                cfg_target = 4'($urandom_range(0, 15));
            end
            step();
        end
        req_valid = 1'b0; cfg_we = 1'b0;
        step(); step();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule